// File: doc/BRIEF.md
# Stepwise Shift-Add Multiply Accumulator

This block gives a small processor datapath a multiply built from single steps. It keeps two accumulator halves, an upper and a lower one, that together act as one double-width register. Each step command looks at the lowest bit of the pair. If that bit is 1, the memory operand is added into the upper half. The pair is then shifted right by one position. The carry out of that addition becomes the new most significant bit, so no product bit is lost.

To form a product, software first clears the upper half and loads the multiplier into the lower half. It then issues as many steps as the multiplier has bits, supplying the multiplicand on the operand bus. With a multiplier of half width and a full run of steps, the whole double-width product ends up in the pair. A shorter run, for example eight steps on an eight-bit multiplier, leaves the product scaled left by the number of unused lower bits. Each half also has its own clear and load control, and loads take the value on the operand bus.

Top module: `shadd_step_acc`

## Requirements
- R1: While reset is high, both halves become zero at the next clock edge.
- R2: A clear request for one half sets only that half to zero at the next edge. A half with no clear or load request keeps its value.
- R3: A load request for one half, with no clear for that half, copies the operand bus into that half at the next edge.
- R4: A step whose lowest pair bit is 0 shifts the pair right by one. The upper half's old bit 0 moves into the lower half's top bit, and a 0 enters the upper half's top bit.
- R5: A step whose lowest pair bit is 1 adds the operand to the upper half as an unsigned value one bit wider. The pair then shifts right by one, and the carry out of the add becomes the new top bit of the upper half.
- R6: When the step strobe is low and no clear or load is requested, both halves hold their values whatever the operand bus carries.
- R7: Any clear or load request in a cycle cancels a step issued in that same cycle. A half with no clear or load of its own then holds its value.
- R8: When clear and load are both requested for the same half, clear wins and the half becomes zero.
- R9: With the upper half cleared and multiplier m in the lower half, n steps with operand a give {upper, lower} = (a * (m mod 2^n)) * 2^(W-n) + (m >> n), where W is the half width. With W = 12, eight steps on an 8-bit m give a*m*16, and twelve steps give the full 24-bit product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Issue one multiply step this cycle |
| mem_i | input | HALF_W | Operand bus, used as the step addend and as the load value |
| clr_hi_i | input | 1 | Clear the upper half |
| clr_lo_i | input | 1 | Clear the lower half |
| ld_hi_i | input | 1 | Load the upper half from mem_i |
| ld_lo_i | input | 1 | Load the lower half from mem_i |
| acc_hi_o | output | HALF_W | Upper accumulator half |
| acc_lo_o | output | HALF_W | Lower accumulator half |

## Verification
The bench builds the block with its default half width of 12. At that width, complete twelve-step runs with all-ones operands drive the adder carry into the top bit, and eight-step runs on 8-bit multipliers test the scaled partial product. A behavioural model predicts both halves on every clock. The stimulus covers multiplication runs with edge and random operands, as well as clashes between steps, clears and loads in the same cycle.

// File: rtl/shadd_pkg.sv
package shadd_pkg;

    localparam int unsigned ACC_HALF_W_DEF = 12;

    typedef enum logic [1:0] {
        HOP_HOLD  = 2'd0,
        HOP_CLEAR = 2'd1,
        HOP_LOAD  = 2'd2,
        HOP_SHIFT = 2'd3
    } half_op_e;

    // Per-half action: clear beats load, any control beats a step.
    function automatic half_op_e pick_op(input logic clr, input logic ld,
                                         input logic any_ctrl, input logic step);
        if (clr)           return HOP_CLEAR;
        else if (ld)       return HOP_LOAD;
        else if (any_ctrl) return HOP_HOLD;
        else if (step)     return HOP_SHIFT;
        else               return HOP_HOLD;
    endfunction

endpackage

// File: rtl/shadd_ctrl.sv
module shadd_ctrl
    import shadd_pkg::*;
(
    input  logic     step_i,
    input  logic     clr_hi_i,
    input  logic     clr_lo_i,
    input  logic     ld_hi_i,
    input  logic     ld_lo_i,
    output half_op_e op_hi_o,
    output half_op_e op_lo_o
);
    logic any_ctrl;

    always_comb begin
        any_ctrl = clr_hi_i | clr_lo_i | ld_hi_i | ld_lo_i;
        op_hi_o  = pick_op(clr_hi_i, ld_hi_i, any_ctrl, step_i);
        op_lo_o  = pick_op(clr_lo_i, ld_lo_i, any_ctrl, step_i);
    end
endmodule

// File: rtl/shadd_step_dp.sv
module shadd_step_dp #(
    parameter int unsigned HALF_W = 12
) (
    input  logic [HALF_W-1:0] hi_i,
    input  logic [HALF_W-1:0] lo_i,
    input  logic [HALF_W-1:0] mem_i,
    output logic [HALF_W-1:0] nxt_hi_o,
    output logic [HALF_W-1:0] nxt_lo_o
);
    localparam int unsigned SUM_W = HALF_W + 1;

    logic [SUM_W-1:0] addend;
    logic [SUM_W-1:0] sum;

    always_comb begin
        addend   = lo_i[0] ? {1'b0, mem_i} : '0;
        sum      = {1'b0, hi_i} + addend;
        nxt_hi_o = sum[SUM_W-1:1];
        nxt_lo_o = {sum[0], lo_i[HALF_W-1:1]};
    end
endmodule

// File: rtl/shadd_half_reg.sv
module shadd_half_reg
    import shadd_pkg::*;
#(
    parameter int unsigned HALF_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  half_op_e          op_i,
    input  logic [HALF_W-1:0] load_i,
    input  logic [HALF_W-1:0] shift_i,
    output logic [HALF_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else begin
            unique case (op_i)
                HOP_CLEAR: q_o <= '0;
                HOP_LOAD:  q_o <= load_i;
                HOP_SHIFT: q_o <= shift_i;
                default:   q_o <= q_o;
            endcase
        end
    end
endmodule

// File: rtl/shadd_step_acc.sv
module shadd_step_acc
    import shadd_pkg::*;
#(
    parameter int unsigned HALF_W = ACC_HALF_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic [HALF_W-1:0] mem_i,
    input  logic              clr_hi_i,
    input  logic              clr_lo_i,
    input  logic              ld_hi_i,
    input  logic              ld_lo_i,
    output logic [HALF_W-1:0] acc_hi_o,
    output logic [HALF_W-1:0] acc_lo_o
);
    localparam int unsigned N_HALF = 2;
    localparam int unsigned IDX_LO = 0;
    localparam int unsigned IDX_HI = 1;

    half_op_e          ops   [N_HALF];
    logic [HALF_W-1:0] shv   [N_HALF];
    logic [HALF_W-1:0] halfq [N_HALF];

    shadd_ctrl u_ctrl (
        .step_i   (step_i),
        .clr_hi_i (clr_hi_i),
        .clr_lo_i (clr_lo_i),
        .ld_hi_i  (ld_hi_i),
        .ld_lo_i  (ld_lo_i),
        .op_hi_o  (ops[IDX_HI]),
        .op_lo_o  (ops[IDX_LO])
    );

    shadd_step_dp #(.HALF_W(HALF_W)) u_dp (
        .hi_i     (halfq[IDX_HI]),
        .lo_i     (halfq[IDX_LO]),
        .mem_i    (mem_i),
        .nxt_hi_o (shv[IDX_HI]),
        .nxt_lo_o (shv[IDX_LO])
    );

    for (genvar g = 0; g < N_HALF; g++) begin : g_half
        shadd_half_reg #(.HALF_W(HALF_W)) u_reg (
            .clk     (clk),
            .rst     (rst),
            .op_i    (ops[g]),
            .load_i  (mem_i),
            .shift_i (shv[g]),
            .q_o     (halfq[g])
        );
    end

    assign acc_hi_o = halfq[IDX_HI];
    assign acc_lo_o = halfq[IDX_LO];

    logic any_ctl;
    assign any_ctl = clr_hi_i | clr_lo_i | ld_hi_i | ld_lo_i;

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (acc_hi_o == '0 && acc_lo_o == '0)); // R1

    AST_CLEAR_HI: assert property (@(posedge clk) disable iff (rst)
        clr_hi_i |=> acc_hi_o == '0); // R2

    AST_LOAD_LO: assert property (@(posedge clk) disable iff (rst)
        (ld_lo_i && !clr_lo_i) |=> acc_lo_o == $past(mem_i)); // R3

    AST_SHIFT_ZERO_BIT: assert property (@(posedge clk) disable iff (rst)
        (step_i && !any_ctl && !acc_lo_o[0]) |=>
        (acc_hi_o == ($past(acc_hi_o) >> 1) &&
         acc_lo_o == {$past(acc_hi_o[0]), $past(acc_lo_o[HALF_W-1:1])})); // R4

    AST_ADD_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (step_i && !any_ctl && acc_lo_o[0]) |=>
        ({acc_hi_o, acc_lo_o[HALF_W-1]} ==
         ({1'b0, $past(acc_hi_o)} + {1'b0, $past(mem_i)}))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !any_ctl) |=> ($stable(acc_hi_o) && $stable(acc_lo_o))); // R6

    AST_STEP_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (step_i && (clr_hi_i || ld_hi_i) && !clr_lo_i && !ld_lo_i) |=>
        $stable(acc_lo_o)); // R7

    AST_CLEAR_OVER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (clr_lo_i && ld_lo_i) |=> acc_lo_o == '0); // R8

endmodule

// File: tb/shadd_step_acc_tb.sv
module shadd_step_acc_tb;
    localparam int  W      = 12;
    localparam time PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         step_i = 1'b0;
    logic [W-1:0] mem_i = '0;
    logic         clr_hi_i = 1'b0, clr_lo_i = 1'b0, ld_hi_i = 1'b0, ld_lo_i = 1'b0;
    logic [W-1:0] acc_hi_o, acc_lo_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    longint ref_hi = 0;
    longint ref_lo = 0;

    always #(PERIOD/2) clk = ~clk;

    shadd_step_acc #(.HALF_W(W)) u_dut (
        .clk(clk), .rst(rst), .step_i(step_i), .mem_i(mem_i),
        .clr_hi_i(clr_hi_i), .clr_lo_i(clr_lo_i),
        .ld_hi_i(ld_hi_i), .ld_lo_i(ld_lo_i),
        .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o)
    );

    task automatic check_val(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step(bit st, bit ch, bit cl, bit lh, bit ll, longint m);
        longint v;
        if (ch || cl || lh || ll) begin
            if (ch) ref_hi = 0; else if (lh) ref_hi = m;
            if (cl) ref_lo = 0; else if (ll) ref_lo = m;
        end else if (st) begin
            v = ref_hi * 4096 + ref_lo;
            if (v % 2 == 1) v = v + m * 4096;
            v = v / 2;
            ref_hi = v / 4096;
            ref_lo = v % 4096;
        end
    endtask

    // Drive one cycle, advance model, compare both halves after the edge.
    task automatic cyc(string tag, bit st, bit ch, bit cl, bit lh, bit ll, int m);
        step_i = st; clr_hi_i = ch; clr_lo_i = cl; ld_hi_i = lh; ld_lo_i = ll;
        mem_i = W'(m);
        @(posedge clk);
        model_step(st, ch, cl, lh, ll, longint'(m));
        #(PERIOD/4);
        check_val({tag, " hi"}, longint'(acc_hi_o), ref_hi);
        check_val({tag, " lo"}, longint'(acc_lo_o), ref_lo);
    endtask

    task automatic mul_run(int m, int a, int n);
        longint prod;
        cyc("R2 R3 setup", 0, 1, 0, 0, 1, m);
        for (int i = 0; i < n; i++) begin
            if (ref_lo % 2 == 1) cyc("R5 add-step", 1, 0, 0, 0, 0, a);
            else                 cyc("R4 shift-step", 1, 0, 0, 0, 0, a);
        end
        prod = longint'(a) * (longint'(m) % (64'd1 << n)) * (64'd1 << (W - n))
             + (longint'(m) >> n);
        check_val("R9 product", longint'({acc_hi_o, acc_lo_o}), prod);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ml [5] = '{0, 255, 1, 255, 128};
        int al [5] = '{0, 4095, 4095, 1, 2048};
        rst = 1'b1;
        mem_i = 12'hABC; step_i = 1'b1;
        repeat (2) @(posedge clk);
        #(PERIOD/4);
        check_val("R1 reset hi", longint'(acc_hi_o), 0);
        check_val("R1 reset lo", longint'(acc_lo_o), 0);
        rst = 1'b0; step_i = 1'b0;

        cyc("R3 load lo", 0, 0, 0, 0, 1, 'h5A3);
        cyc("R3 load hi", 0, 0, 0, 1, 0, 'hF0F);
        cyc("R2 clear hi", 0, 1, 0, 0, 0, 'h123);
        cyc("R3 reload hi", 0, 0, 0, 1, 0, 'h777);
        cyc("R2 clear lo", 0, 0, 1, 0, 0, 'h321);
        cyc("R3 reload lo", 0, 0, 0, 0, 1, 'h0F1);
        cyc("R6 idle", 0, 0, 0, 0, 0, 'hFFF);
        cyc("R6 idle", 0, 0, 0, 0, 0, 'h001);
        cyc("R7 step with hi load", 1, 0, 0, 1, 0, 'h8AA);
        cyc("R7 step with lo clear", 1, 0, 1, 0, 0, 'h555);
        cyc("R8 clear over load hi", 0, 1, 0, 1, 0, 'hBBB);
        cyc("R8 clear over load lo", 1, 0, 1, 0, 1, 'hCCC);

        for (int k = 0; k < 5; k++) mul_run(ml[k], al[k], 8);
        for (int k = 0; k < 20; k++) mul_run(int'($urandom_range(0, 255)),
                                             int'($urandom_range(0, 4095)), 8);
        mul_run(4095, 4095, 12);
        mul_run(2730, 3001, 12);
        mul_run(4095, 4095, 5);

        cyc("R7 step with lo load", 1, 0, 0, 0, 1, 'hFFF);
        cyc("R5 add-step carry", 1, 0, 0, 0, 0, 'hFFF);
        cyc("R6 idle after run", 0, 0, 0, 0, 0, 'h000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule